// File: doc/BRIEF.md
# Asynchronous memory bank enable decoder

This block is the control side of an external asynchronous memory controller. It keeps a 16-bit global control register and two 32-bit bank timing registers behind a small synchronous register port. It also turns each external-memory bus address into at most one bank chip select. Four banks of equal, power-of-two size sit back to back from a base address. A 3-bit enable count in the global register decides how many of them, counted from bank 0 upward, respond.

The timing registers are only stored and read back; no waveform timing, wait states or arbitration are produced here. A register access receives its read data and error flag one cycle after it is presented. A bus access receives its registered chip select, or an unmapped flag, one cycle after it is presented.

Top module: `amc_bank_ctrl`

## Requirements
- R1: After reset the global control register reads 0x00F2, both bank control registers read 0xFFC2FFC2, and `mem_cs`, `mem_unmapped` and `reg_err` are low.
- R2: The enable count is bits [3:1] of the global control register, with values 4 to 7 treated as 4. Bank i responds only when i is below that count, so the enabled banks are always bank 0 up to count-1.
- R3: Bank i covers the byte addresses from BANK_BASE + i*2^BANK_SIZE_LOG2 up to, but not including, BANK_BASE + (i+1)*2^BANK_SIZE_LOG2. A bus access (`mem_valid` high) to an enabled bank raises bit i of `mem_cs` and no other bit in the following cycle.
- R4: A bus access to a disabled bank, below BANK_BASE, or at or above BANK_BASE + 4*2^BANK_SIZE_LOG2 raises `mem_unmapped` in the following cycle with `mem_cs` all zero.
- R5: The global control register at offset 0x0 accepts only `reg_size` = 2. Any other size sets `reg_err` in the following cycle, discards a write, and returns 0 on a read.
- R6: The bank control registers at offsets 0x4 and 0x8 store all 32 bits of `reg_wdata` on a write of either size, and a read returns the stored value. The global control register returns its value in bits [15:0] with bits [31:16] zero.
- R7: An access to any offset other than 0x0, 0x4 or 0x8 sets `reg_err` in the following cycle, changes no register, and returns 0 on a read.
- R8: A valid write to the global control register governs a bus access presented in the same cycle and every later one.
- R9: `mem_cs` has at most one bit set in any cycle, and a cycle without `mem_valid` is followed by a cycle with `mem_cs` zero and `mem_unmapped` low.
- R10: `reg_err` is high only in the cycle after a failing register access. `reg_rdata` is zero except in the cycle after a successful read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | REG_AW | Byte offset of the register |
| reg_size | input | 3 | Access size in bytes (2 or 4) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the access |
| reg_err | output | 1 | Access error, one cycle after the access |
| mem_valid | input | 1 | External-memory bus access strobe |
| mem_addr | input | ADDR_W | External-memory bus address |
| mem_cs | output | 4 | Registered one-hot bank chip selects |
| mem_unmapped | output | 1 | Registered flag for an access that hits no enabled bank |

## Verification
A write to the global control register and a bus access can fall in the same cycle. In that case the access must be decoded with the count being written, not with the stored one. The bench provokes this by sweeping all eight values of the enable field. Each write is paired with a bus access in the same cycle, aimed at the bank that sits exactly on the new count boundary. The behavioural model applies the write before decoding, so a chip select or unmapped flag that follows the stale count fails against the expected value in the next cycle.

// File: rtl/amc_pkg.sv
package amc_pkg;

  localparam int unsigned NBANK = 4;
  localparam logic [15:0] GCTL_RST = 16'h00F2;
  localparam logic [31:0] BCTL_RST = 32'hFFC2FFC2;

  typedef enum logic [1:0] {
    SEL_GCTL,
    SEL_BCTL0,
    SEL_BCTL1,
    SEL_NONE
  } reg_sel_e;

  // Enable count from the global control word, saturated at the bank count.
  function automatic logic [2:0] bank_count(input logic [15:0] g);
    logic [2:0] f;
    f = g[3:1];
    return (f > 3'(NBANK)) ? 3'(NBANK) : f;
  endfunction

  function automatic reg_sel_e decode_offset(input logic [31:0] off);
    case (off)
      32'h0:   return SEL_GCTL;
      32'h4:   return SEL_BCTL0;
      32'h8:   return SEL_BCTL1;
      default: return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/amc_regs.sv
module amc_regs
  import amc_pkg::*;
#(
  parameter int unsigned REG_AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [2:0]        reg_size,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              reg_err,
  output logic [15:0]       gctl_q,
  output logic [15:0]       gctl_eff
);

  localparam int unsigned PAD = 32 - REG_AW;

  reg_sel_e    sel;
  logic        bad_off;
  logic        bad_width;
  logic        acc_err;
  logic        acc_ok;
  logic        wr_gctl;
  logic        wr_b0;
  logic        wr_b1;
  logic [31:0] bctl0_q;
  logic [31:0] bctl1_q;
  logic [31:0] rd_next;

  assign sel       = decode_offset({{PAD{1'b0}}, reg_addr});
  assign bad_off   = (sel == SEL_NONE);
  assign bad_width = (sel == SEL_GCTL) && (reg_size != 3'd2);
  assign acc_err   = reg_valid && (bad_off || bad_width);
  assign acc_ok    = reg_valid && !bad_off && !bad_width;
  assign wr_gctl   = acc_ok && reg_write && (sel == SEL_GCTL);
  assign wr_b0     = acc_ok && reg_write && (sel == SEL_BCTL0);
  assign wr_b1     = acc_ok && reg_write && (sel == SEL_BCTL1);

  // Write forwarding: decoding in the same cycle sees the new count.
  assign gctl_eff = wr_gctl ? reg_wdata[15:0] : gctl_q;

  always_comb begin
    rd_next = '0;
    if (acc_ok && !reg_write) begin
      case (sel)
        SEL_GCTL:  rd_next = {16'h0000, gctl_q};
        SEL_BCTL0: rd_next = bctl0_q;
        SEL_BCTL1: rd_next = bctl1_q;
        default:   rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gctl_q    <= GCTL_RST;
      bctl0_q   <= BCTL_RST;
      bctl1_q   <= BCTL_RST;
      reg_rdata <= '0;
      reg_err   <= 1'b0;
    end else begin
      if (wr_gctl) gctl_q  <= reg_wdata[15:0];
      if (wr_b0)   bctl0_q <= reg_wdata;
      if (wr_b1)   bctl1_q <= reg_wdata;
      reg_rdata <= rd_next;
      reg_err   <= acc_err;
    end
  end

endmodule

// File: rtl/amc_bank_window.sv
module amc_bank_window #(
  parameter int unsigned ADDR_W = 32,
  parameter logic [ADDR_W:0] LO = '0,
  parameter logic [ADDR_W:0] HI = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);

  logic [ADDR_W:0] a_ext;

  assign a_ext = {1'b0, addr};
  assign hit   = (a_ext >= LO) && (a_ext < HI);

endmodule

// File: rtl/amc_bank_decode.sv
module amc_bank_decode
  import amc_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BANK_BASE = 32'h2000_0000,
  parameter int unsigned BANK_SIZE_LOG2 = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_valid,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [15:0]       gctl_eff,
  output logic [NBANK-1:0]  mem_cs,
  output logic              mem_unmapped
);

  localparam int unsigned EW = ADDR_W + 1;

  logic [2:0]       en_count;
  logic [NBANK-1:0] win_hit;
  logic [NBANK-1:0] bank_en;
  logic [NBANK-1:0] cs_next;
  logic             unmapped_next;

  assign en_count = bank_count(gctl_eff);

  for (genvar i = 0; i < NBANK; i++) begin : g_bank
    localparam logic [EW-1:0] LO_I =
      EW'(BANK_BASE) + (EW'(i) << BANK_SIZE_LOG2);
    localparam logic [EW-1:0] HI_I =
      EW'(BANK_BASE) + (EW'(i + 1) << BANK_SIZE_LOG2);

    amc_bank_window #(
      .ADDR_W(ADDR_W),
      .LO    (LO_I),
      .HI    (HI_I)
    ) u_win (
      .addr(mem_addr),
      .hit (win_hit[i])
    );

    assign bank_en[i] = (3'(i) < en_count);
  end

  assign cs_next       = mem_valid ? (win_hit & bank_en) : '0;
  assign unmapped_next = mem_valid && (cs_next == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_cs       <= '0;
      mem_unmapped <= 1'b0;
    end else begin
      mem_cs       <= cs_next;
      mem_unmapped <= unmapped_next;
    end
  end

endmodule

// File: rtl/amc_bank_ctrl.sv
module amc_bank_ctrl
  import amc_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BANK_BASE = 32'h2000_0000,
  parameter int unsigned BANK_SIZE_LOG2 = 20,
  parameter int unsigned REG_AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [2:0]        reg_size,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              reg_err,
  input  logic              mem_valid,
  input  logic [ADDR_W-1:0] mem_addr,
  output logic [3:0]        mem_cs,
  output logic              mem_unmapped
);

  logic [15:0] gctl_q;
  logic [15:0] gctl_eff;

  amc_regs #(
    .REG_AW(REG_AW)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_valid(reg_valid),
    .reg_write(reg_write),
    .reg_addr (reg_addr),
    .reg_size (reg_size),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .reg_err  (reg_err),
    .gctl_q   (gctl_q),
    .gctl_eff (gctl_eff)
  );

  amc_bank_decode #(
    .ADDR_W        (ADDR_W),
    .BANK_BASE     (BANK_BASE),
    .BANK_SIZE_LOG2(BANK_SIZE_LOG2)
  ) u_dec (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_valid   (mem_valid),
    .mem_addr    (mem_addr),
    .gctl_eff    (gctl_eff),
    .mem_cs      (mem_cs),
    .mem_unmapped(mem_unmapped)
  );

endmodule

// File: rtl/amc_bank_ctrl_checks.sv
module amc_bank_ctrl_checks
  import amc_pkg::*;
#(
  parameter int unsigned REG_AW = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_valid,
  input logic              reg_write,
  input logic [REG_AW-1:0] reg_addr,
  input logic [2:0]        reg_size,
  input logic [31:0]       reg_rdata,
  input logic              reg_err,
  input logic              mem_valid,
  input logic [3:0]        mem_cs,
  input logic              mem_unmapped,
  input logic [15:0]       gctl_q
);

  logic gctl_acc;
  logic off_ok;

  assign gctl_acc = reg_valid && (reg_addr == '0);
  assign off_ok   = (reg_addr == REG_AW'(0)) || (reg_addr == REG_AW'(4)) ||
                    (reg_addr == REG_AW'(8));

  a_r9_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mem_cs));

  a_r4_unmapped_no_cs: assert property (@(posedge clk) disable iff (!rst_n)
    mem_unmapped |-> (mem_cs == 4'b0000));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_valid |=> (mem_cs == 4'b0000) && !mem_unmapped);

  a_r10_err_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_valid |=> !reg_err && (reg_rdata == 32'h0));

  a_r5_wide_gctl_err: assert property (@(posedge clk) disable iff (!rst_n)
    (gctl_acc && reg_size != 3'd2) |=> reg_err && (reg_rdata == 32'h0));

  a_r5_wide_gctl_discard: assert property (@(posedge clk) disable iff (!rst_n)
    (gctl_acc && reg_write && reg_size != 3'd2) |=> $stable(gctl_q));

  a_r7_bad_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && !off_ok) |=> reg_err && (reg_rdata == 32'h0));

  a_r7_bad_offset_keeps_gctl: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && reg_write && !off_ok) |=> $stable(gctl_q));

  for (genvar k = 0; k < 4; k++) begin : g_prefix
    a_r2_prefix: assert property (@(posedge clk) disable iff (!rst_n)
      mem_cs[k] |-> (int'(bank_count(gctl_q)) > k));
  end

endmodule

bind amc_bank_ctrl amc_bank_ctrl_checks #(
  .REG_AW(REG_AW)
) u_checks (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_valid   (reg_valid),
  .reg_write   (reg_write),
  .reg_addr    (reg_addr),
  .reg_size    (reg_size),
  .reg_rdata   (reg_rdata),
  .reg_err     (reg_err),
  .mem_valid   (mem_valid),
  .mem_cs      (mem_cs),
  .mem_unmapped(mem_unmapped),
  .gctl_q      (gctl_q)
);

// File: tb/tb_amc_bank_ctrl.sv
`timescale 1ns/1ps
module tb_amc_bank_ctrl;

  localparam longint BASE = 64'h2000_0000;
  localparam longint BSZ  = 64'h0010_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_valid = 1'b0;
  logic        reg_write = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [2:0]  reg_size = 3'd4;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_err;
  logic        mem_valid = 1'b0;
  logic [31:0] mem_addr = '0;
  logic [3:0]  mem_cs;
  logic        mem_unmapped;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // behavioural model state
  int m_g  = 'h00F2;
  int m_b0 = 'hFFC2FFC2;
  int m_b1 = 'hFFC2FFC2;
  bit rd_is_reset = 0;

  always #5 clk = ~clk;

  amc_bank_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
    .reg_size(reg_size), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_err(reg_err), .mem_valid(mem_valid), .mem_addr(mem_addr),
    .mem_cs(mem_cs), .mem_unmapped(mem_unmapped)
  );

  task automatic chk(input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  // One clock: drive inputs, predict, check after the edge.
  task automatic cycle(input bit rv, input bit rw, input int ra, input int rs,
                       input int wd, input bit mv, input longint ma);
    int     e_rd, cnt, bank;
    bit     e_err, bad_off, bad_w, e_un, gwrite;
    int     e_cs;
    string  t_err, t_rd, t_cs;
    reg_valid = rv; reg_write = rw; reg_addr = 4'(ra); reg_size = 3'(rs);
    reg_wdata = wd; mem_valid = mv; mem_addr = 32'(ma);
    e_rd = 0; e_err = 0; gwrite = 0; t_err = "R10"; t_rd = "R10";
    if (rv) begin
      bad_off = !(ra == 0 || ra == 4 || ra == 8);
      bad_w   = (ra == 0) && (rs != 2);
      e_err   = bad_off || bad_w;
      t_err   = bad_off ? "R7" : (bad_w ? "R5" : "R10");
      t_rd    = t_err;
      if (!e_err) begin
        if (rw) begin
          if (ra == 0) begin m_g = wd & 'hFFFF; gwrite = 1; end
          else if (ra == 4) m_b0 = wd;
          else m_b1 = wd;
        end else begin
          t_rd = rd_is_reset ? "R1" : "R6";
          e_rd = (ra == 0) ? m_g : ((ra == 4) ? m_b0 : m_b1);
        end
      end
    end
    e_cs = 0; e_un = 0; t_cs = "R9";
    if (mv) begin
      cnt = (m_g >> 1) & 7;
      if (cnt > 4) cnt = 4;
      if (ma >= BASE && ma < BASE + 4 * BSZ) begin
        bank = int'((ma - BASE) / BSZ);
        if (bank < cnt) begin e_cs = 1 << bank; t_cs = "R3"; end
        else begin e_un = 1; t_cs = "R2"; end
      end else begin
        e_un = 1; t_cs = "R4";
      end
      if (gwrite) t_cs = "R8";
    end
    @(negedge clk);
    chk(t_err, "reg_err", longint'(reg_err), longint'(e_err));
    chk(t_rd, "reg_rdata", longint'(reg_rdata), longint'(unsigned'(e_rd)));
    chk(t_cs, "mem_cs", longint'(mem_cs), longint'(e_cs));
    chk(e_un ? "R4" : t_cs, "mem_unmapped", longint'(mem_unmapped), longint'(e_un));
  endtask

  task automatic rd(input int ra, input int rs);
    cycle(1, 0, ra, rs, 0, 0, 0);
  endtask

  task automatic wr(input int ra, input int rs, input int wd);
    cycle(1, 1, ra, rs, wd, 0, 0);
  endtask

  task automatic probe_all();
    for (int b = 0; b < 4; b++) begin
      cycle(0, 0, 0, 2, 0, 1, BASE + b * BSZ);
      cycle(0, 0, 0, 2, 0, 1, BASE + (b + 1) * BSZ - 1);
    end
    cycle(0, 0, 0, 2, 0, 1, BASE - 1);
    cycle(0, 0, 0, 2, 0, 1, BASE + 4 * BSZ);
    cycle(0, 0, 0, 2, 0, 0, BASE);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet while in reset
    chk("R1", "mem_cs in reset", longint'(mem_cs), 0);
    chk("R1", "mem_unmapped in reset", longint'(mem_unmapped), 0);
    chk("R1", "reg_err in reset", longint'(reg_err), 0);
    rst_n = 1'b1;
    rd_is_reset = 1;
    rd(0, 2); rd(4, 4); rd(8, 4);
    rd_is_reset = 0;
    // R2 R3 R4: default count of one bank
    probe_all();
    // R8: every count value, each write paired with an access on the boundary
    for (int f = 0; f < 8; f++) begin
      cycle(1, 1, 0, 2, 'hAB00 | (f << 1), 1, BASE + (f % 4) * BSZ + 'h123);
      cycle(1, 1, 0, 2, 'hAB00 | (f << 1), 1, BASE + ((f + 3) % 4) * BSZ);
      probe_all();
      rd(0, 2);
    end
    // R5: wrong size on global control
    wr(0, 2, 'h0006);
    wr(0, 4, 'h0008);
    rd(0, 4);
    rd(0, 2);
    cycle(1, 1, 0, 4, 'h0000, 1, BASE + 2 * BSZ);
    probe_all();
    // R6: bank timing storage
    wr(4, 4, 'h1234_5678); rd(4, 4);
    wr(8, 2, 'hDEAD_BEEF); rd(8, 2);
    wr(4, 4, 'h0F0F_A5A5); rd(4, 4); rd(8, 4);
    // R7: offsets outside the map, then confirm nothing moved
    wr('hC, 4, 'h5555_5555); rd('hC, 4);
    wr('h2, 2, 'h0000);      rd('h6, 4);
    wr('h1, 4, 'hFFFF_FFFF); wr('hF, 2, 'h0002);
    rd(0, 2); rd(4, 4); rd(8, 4);
    probe_all();
    // R10: idle cycles
    repeat (4) cycle(0, 0, 0, 2, 0, 0, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule